// File: doc/BRIEF.md
# Dual-Slot SD Host Register Front End

This block sits on a 32-bit register bus in front of two SD host slot controllers and decodes a 4 KiB window. The lowest 256 bytes of the window hold a shared bank. It has two fixed reset words, general storage words, and an interrupt status word. Certain shared offsets do not address storage in the bank. Instead they reach two words that belong to each slot: the capability word and the maximum-current word. The block holds both of these words and drives them out to the slot controllers.

The second and third 256-byte pages of the window are forwarded to slot 0 and slot 1. A forwarded access waits for the slot's own ready signal before it completes.

Each slot's interrupt line is copied into the status word. The bits of the status word are combined into one registered interrupt output.

A shared-bank access completes one cycle after its strobe. Any other access to a non-slot page also completes one cycle after its strobe. An access to a slot page completes when the slot answers. The host issues one strobe at a time and waits for ready before it issues the next. A strobe that arrives while a forwarded access is outstanding is not accepted.

Top module: `sdg_dual_slot_glue`

## Requirements
- R1: After reset, shared offset 0x00 reads 0x00030000 and offset 0x04 reads 0x00000005. Every other stored shared offset and the status word read 0. Each slot's capability word reads 0x01E80080 and appears on `slot_cap`. Each maximum-current word reads 0. `irq` is low.
- R2: Each shared offset other than 0x10, 0x18, 0x20, 0x28 and 0xFC is a read/write storage word. This covers 0x00, 0x04, 0x08, 0x40, 0xEC and 0xF0. A read returns the last value written to that offset.
- R3: An accepted access to the shared page or to an unmapped page raises `bus_ready` for exactly one cycle. That cycle is the one after the strobe cycle. For a read, `bus_rdata` carries the data in that cycle. For a write, `bus_rdata` is zero.
- R4: Offsets 0x10 and 0x18 read and write slot 0's capability and maximum-current words. Offsets 0x20 and 0x28 do the same for slot 1. A write shows on `slot_cap` or `slot_maxcur` bits [32n+31:32n] for slot n.
- R5: Bit n of the status word at 0xFC equals the level that `slot_irq[n]` had one cycle earlier. Bits above the slot count read 0.
- R6: A write to 0xFC leaves the status word unchanged.
- R7: `irq` equals the OR of the status bits, delayed by one register. It therefore rises and falls two cycles after the slot interrupt lines change.
- R8: An access to byte address 0x100*(n+1)+k, with k from 0x00 to 0xFF, raises `slot_req[n]` alone. It presents k on `slot_addr`, together with the write flag and the write data, and holds these until `slot_ready[n]`. The bus completes in that cycle, with `bus_rdata` set to slot n's read data.
- R9: An access to an address from 0x300 to 0xFFF has no effect on any register and reaches no slot. It reads zero and completes as in R3.
- R10: An access with `bus_be` not equal to 4'hF is not a full-word access. An access with `bus_addr[1:0]` not zero is also not a full-word access. Such an access has no effect on any register, reaches no slot, reads zero and completes as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | One-cycle access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the window |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access complete |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| slot_req | output | 2 | Per-slot request, held until that slot's ready |
| slot_write | output | 1 | Write flag of the forwarded access |
| slot_addr | output | 8 | Byte offset inside the slot page |
| slot_wdata | output | 32 | Write data of the forwarded access |
| slot_ready | input | 2 | Per-slot completion |
| slot_rdata | input | 64 | Per-slot read data, slot n in bits [32n+31:32n] |
| slot_irq | input | 2 | Per-slot interrupt levels |
| slot_cap | output | 64 | Per-slot capability words |
| slot_maxcur | output | 64 | Per-slot maximum-current words |
| irq | output | 1 | Combined interrupt |

## Verification
Decode faults are the hardest to see. A wrong page or index decode writes a neighbouring word or the wrong slot's alias. That error stays hidden until the affected offset or the `slot_cap`/`slot_maxcur` port is read. For this reason the bench reads back all neighbours, and it checks the alias ports after each alias write. A stuck or misrouted forwarding state shows as a bus access that never completes, or as a request on the other slot. This is visible within the slot's response latency. A status or interrupt register with the wrong delay is caught by sampling `irq` one and two cycles after a slot line changes, and by reading 0xFC.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

   localparam int WORD_W       = 32;
   localparam int BE_W         = WORD_W / 8;
   localparam int BANK_WORDS   = 64;
   localparam int IDX_W        = $clog2(BANK_WORDS);
   localparam int PAGE_OFS_W   = 8;

   localparam int IDENT_IDX    = 0;
   localparam int DEBNC_IDX    = 1;
   localparam int STAT_IDX     = BANK_WORDS - 1;
   localparam int CAP_BASE_IDX = 4;
   localparam int CUR_BASE_IDX = 6;
   localparam int ALIAS_STRIDE = 4;

   localparam logic [WORD_W-1:0] IDENT_RST = 32'h0003_0000;
   localparam logic [WORD_W-1:0] DEBNC_RST = 32'h0000_0005;

   typedef enum logic [1:0] {
      RGN_NONE   = 2'd0,
      RGN_SHARED = 2'd1,
      RGN_SLOT   = 2'd2
   } rgn_e;

   function automatic logic [WORD_W-1:0] bank_reset_word(input int idx);
      if (idx == IDENT_IDX)      return IDENT_RST;
      else if (idx == DEBNC_IDX) return DEBNC_RST;
      else                       return '0;
   endfunction

endpackage

// File: rtl/sdg_addr_decode.sv
module sdg_addr_decode
   import sdg_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_SLOTS = 2,
   localparam int SIW      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BE_W-1:0]   be_i,
   output rgn_e              rgn_o,
   output logic [SIW-1:0]    slot_o
);

   logic       hi_zero;
   logic [3:0] page;
   logic       full_word;

   generate
      if (ADDR_W > 12) begin : g_hi
         assign hi_zero = ~|addr_i[ADDR_W-1:12];
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign page      = addr_i[11:8];
   assign full_word = (be_i == {BE_W{1'b1}}) && (addr_i[1:0] == 2'b00);

   always_comb begin
      rgn_o  = RGN_NONE;
      slot_o = '0;
      if (full_word && hi_zero) begin
         if (page == 4'd0) begin
            rgn_o = RGN_SHARED;
         end
         for (int n = 0; n < NUM_SLOTS; n++) begin
            if (page == 4'(n + 1)) begin
               rgn_o  = RGN_SLOT;
               slot_o = SIW'(n);
            end
         end
      end
   end

endmodule

// File: rtl/sdg_shared_bank.sv
module sdg_shared_bank
   import sdg_pkg::*;
#(
   parameter int                NUM_SLOTS = 2,
   parameter logic [WORD_W-1:0] CAP_RESET = 32'h01E8_0080
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en_i,
   input  logic [IDX_W-1:0]            idx_i,
   input  logic [WORD_W-1:0]           wdata_i,
   input  logic [NUM_SLOTS-1:0]        slot_irq_i,
   output logic [WORD_W-1:0]           rdata_o,
   output logic [NUM_SLOTS*WORD_W-1:0] cap_o,
   output logic [NUM_SLOTS*WORD_W-1:0] cur_o,
   output logic [NUM_SLOTS-1:0]        stat_o
);

   logic [WORD_W-1:0]    mem_q [BANK_WORDS];
   logic [WORD_W-1:0]    cap_q [NUM_SLOTS];
   logic [WORD_W-1:0]    cur_q [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] cap_hit;
   logic [NUM_SLOTS-1:0] cur_hit;
   logic [NUM_SLOTS-1:0] stat_q;
   logic                 stat_hit;
   logic                 plain_hit;

   assign stat_hit  = (idx_i == IDX_W'(STAT_IDX));
   assign plain_hit = ~stat_hit && ~|cap_hit && ~|cur_hit;

   genvar n;
   generate
      for (n = 0; n < NUM_SLOTS; n++) begin : g_alias
         assign cap_hit[n] = (idx_i == IDX_W'(CAP_BASE_IDX + ALIAS_STRIDE * n));
         assign cur_hit[n] = (idx_i == IDX_W'(CUR_BASE_IDX + ALIAS_STRIDE * n));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cap_q[n] <= CAP_RESET;
               cur_q[n] <= '0;
            end else begin
               if (wr_en_i && cap_hit[n]) cap_q[n] <= wdata_i;
               if (wr_en_i && cur_hit[n]) cur_q[n] <= wdata_i;
            end
         end

         assign cap_o[n*WORD_W +: WORD_W] = cap_q[n];
         assign cur_o[n*WORD_W +: WORD_W] = cur_q[n];

         AST_ALIAS_CAP_WR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && cap_hit[n]) |=> (cap_o[n*WORD_W +: WORD_W] == $past(wdata_i))); // R4
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < BANK_WORDS; i++) begin
            mem_q[i] <= bank_reset_word(i);
         end
      end else if (wr_en_i && plain_hit) begin
         mem_q[idx_i] <= wdata_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= slot_irq_i;
   end

   assign stat_o = stat_q;

   always_comb begin
      rdata_o = mem_q[idx_i];
      for (int k = 0; k < NUM_SLOTS; k++) begin
         if (cap_hit[k]) rdata_o = cap_q[k];
         if (cur_hit[k]) rdata_o = cur_q[k];
      end
      if (stat_hit) begin
         rdata_o = '0;
         rdata_o[NUM_SLOTS-1:0] = stat_q;
      end
   end

   AST_STAT_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && stat_hit) |=> (stat_o == $past(slot_irq_i))); // R6

endmodule

// File: rtl/sdg_slot_fwd.sv
module sdg_slot_fwd
   import sdg_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   localparam int SIW      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic [SIW-1:0]              start_slot_i,
   input  logic                        start_write_i,
   input  logic [PAGE_OFS_W-1:0]       start_addr_i,
   input  logic [WORD_W-1:0]           start_wdata_i,
   output logic                        busy_o,
   output logic                        done_o,
   output logic [WORD_W-1:0]           rdata_o,
   output logic [NUM_SLOTS-1:0]        slot_req_o,
   output logic                        slot_write_o,
   output logic [PAGE_OFS_W-1:0]       slot_addr_o,
   output logic [WORD_W-1:0]           slot_wdata_o,
   input  logic [NUM_SLOTS-1:0]        slot_ready_i,
   input  logic [NUM_SLOTS*WORD_W-1:0] slot_rdata_i
);

   logic                  busy_q;
   logic [SIW-1:0]        pend_q;
   logic                  we_q;
   logic [PAGE_OFS_W-1:0] addr_q;
   logic [WORD_W-1:0]     wd_q;
   logic [WORD_W-1:0]     rd_arr [NUM_SLOTS];
   logic                  pend_ready;

   genvar n;
   generate
      for (n = 0; n < NUM_SLOTS; n++) begin : g_slot
         assign rd_arr[n]     = slot_rdata_i[n*WORD_W +: WORD_W];
         assign slot_req_o[n] = busy_q && (pend_q == SIW'(n));
      end
   endgenerate

   assign pend_ready = slot_ready_i[pend_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= '0;
         we_q   <= 1'b0;
         addr_q <= '0;
         wd_q   <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q <= 1'b1;
            pend_q <= start_slot_i;
            we_q   <= start_write_i;
            addr_q <= start_addr_i;
            wd_q   <= start_wdata_i;
         end
      end else if (pend_ready) begin
         busy_q <= 1'b0;
      end
   end

   assign busy_o       = busy_q;
   assign done_o       = busy_q && pend_ready;
   assign rdata_o      = rd_arr[pend_q];
   assign slot_write_o = we_q;
   assign slot_addr_o  = addr_q;
   assign slot_wdata_o = wd_q;

   AST_ONE_SLOT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_req_o)); // R8
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (|slot_req_o && !(|(slot_req_o & slot_ready_i))) |=>
         ($stable(slot_req_o) && $stable(slot_addr_o) && $stable(slot_wdata_o))); // R8

endmodule

// File: rtl/sdg_dual_slot_glue.sv
module sdg_dual_slot_glue
   import sdg_pkg::*;
#(
   parameter int                ADDR_W    = 12,
   parameter int                NUM_SLOTS = 2,
   parameter logic [WORD_W-1:0] CAP_RESET = 32'h01E8_0080
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_valid,
   input  logic                        bus_write,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [BE_W-1:0]             bus_be,
   input  logic [WORD_W-1:0]           bus_wdata,
   output logic                        bus_ready,
   output logic [WORD_W-1:0]           bus_rdata,
   output logic [NUM_SLOTS-1:0]        slot_req,
   output logic                        slot_write,
   output logic [PAGE_OFS_W-1:0]       slot_addr,
   output logic [WORD_W-1:0]           slot_wdata,
   input  logic [NUM_SLOTS-1:0]        slot_ready,
   input  logic [NUM_SLOTS*WORD_W-1:0] slot_rdata,
   input  logic [NUM_SLOTS-1:0]        slot_irq,
   output logic [NUM_SLOTS*WORD_W-1:0] slot_cap,
   output logic [NUM_SLOTS*WORD_W-1:0] slot_maxcur,
   output logic                        irq
);

   localparam int SIW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > 8) begin : g_bad_slots
         $error("NUM_SLOTS must lie in 1..8 so slot pages and aliases fit");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("ADDR_W must cover the 4 KiB window");
      end
   endgenerate

   rgn_e              rgn;
   logic [SIW-1:0]    dec_slot;
   logic              fwd_busy;
   logic              fwd_done;
   logic [WORD_W-1:0] fwd_rdata;
   logic              accept;
   logic              bank_wr;
   logic [WORD_W-1:0] bank_rdata;
   logic [NUM_SLOTS-1:0] stat;
   logic              loc_ready_q;
   logic [WORD_W-1:0] loc_data_q;
   logic              irq_q;
   logic [1:0]        warm_q;

   sdg_addr_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
      .addr_i (bus_addr),
      .be_i   (bus_be),
      .rgn_o  (rgn),
      .slot_o (dec_slot)
   );

   assign accept  = bus_valid && !fwd_busy;
   assign bank_wr = accept && bus_write && (rgn == RGN_SHARED);

   sdg_shared_bank #(.NUM_SLOTS(NUM_SLOTS), .CAP_RESET(CAP_RESET)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (bank_wr),
      .idx_i      (bus_addr[IDX_W+1:2]),
      .wdata_i    (bus_wdata),
      .slot_irq_i (slot_irq),
      .rdata_o    (bank_rdata),
      .cap_o      (slot_cap),
      .cur_o      (slot_maxcur),
      .stat_o     (stat)
   );

   sdg_slot_fwd #(.NUM_SLOTS(NUM_SLOTS)) u_fwd (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (accept && (rgn == RGN_SLOT)),
      .start_slot_i  (dec_slot),
      .start_write_i (bus_write),
      .start_addr_i  (bus_addr[PAGE_OFS_W-1:0]),
      .start_wdata_i (bus_wdata),
      .busy_o        (fwd_busy),
      .done_o        (fwd_done),
      .rdata_o       (fwd_rdata),
      .slot_req_o    (slot_req),
      .slot_write_o  (slot_write),
      .slot_addr_o   (slot_addr),
      .slot_wdata_o  (slot_wdata),
      .slot_ready_i  (slot_ready),
      .slot_rdata_i  (slot_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_ready_q <= 1'b0;
         loc_data_q  <= '0;
         irq_q       <= 1'b0;
         warm_q      <= '0;
      end else begin
         loc_ready_q <= accept && (rgn != RGN_SLOT);
         loc_data_q  <= (accept && !bus_write && (rgn == RGN_SHARED)) ? bank_rdata : '0;
         irq_q       <= |stat;
         if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      end
   end

   assign irq       = irq_q;
   assign bus_ready = loc_ready_q || fwd_done;
   assign bus_rdata = loc_ready_q ? loc_data_q : (fwd_done ? fwd_rdata : '0);

   AST_LOCAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && rgn != RGN_SLOT) |=> (bus_ready && !fwd_busy)); // R3
   AST_IRQ_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd3) |-> (irq == $past(|slot_irq, 2))); // R7
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !bus_write && (bus_addr[11:8] >= 4'(NUM_SLOTS + 1))) |=>
         (bus_rdata == '0 && slot_req == '0)); // R9
   AST_PARTIAL_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (bus_be != {BE_W{1'b1}})) |=> (bus_rdata == '0 && slot_req == '0)); // R10

endmodule

// File: tb/sdg_dual_slot_glue_test.sv
module sdg_dual_slot_glue_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] CAP_DEF = 32'h01E8_0080;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_valid, bus_write;
   logic [11:0] bus_addr;
   logic [3:0]  bus_be;
   logic [31:0] bus_wdata;
   logic        bus_ready;
   logic [31:0] bus_rdata;
   logic [1:0]  slot_req;
   logic        slot_write;
   logic [7:0]  slot_addr;
   logic [31:0] slot_wdata;
   logic [1:0]  slot_ready;
   logic [63:0] slot_rdata;
   logic [1:0]  slot_irq;
   logic [63:0] slot_cap, slot_maxcur;
   logic        irq;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   int          req_cnt [2];
   int          wait_cnt [2];
   logic [7:0]  last_addr [2];
   logic        last_we [2];
   logic [31:0] last_wd [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   sdg_dual_slot_glue uut (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
      .slot_req(slot_req), .slot_write(slot_write), .slot_addr(slot_addr),
      .slot_wdata(slot_wdata), .slot_ready(slot_ready), .slot_rdata(slot_rdata),
      .slot_irq(slot_irq), .slot_cap(slot_cap), .slot_maxcur(slot_maxcur), .irq(irq)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // slot stubs: slot 0 answers after 1 cycle, slot 1 after 3
   initial begin
      slot_ready = '0;
      slot_rdata = '0;
      for (int n = 0; n < 2; n++) begin
         req_cnt[n] = 0; wait_cnt[n] = 0; last_addr[n] = '0; last_we[n] = 0; last_wd[n] = '0;
      end
      forever begin
         @(negedge clk);
         for (int n = 0; n < 2; n++) begin
            if (slot_ready[n]) begin
               slot_ready[n] = 1'b0;
            end else if (slot_req[n]) begin
               wait_cnt[n]++;
               if (wait_cnt[n] == ((n == 0) ? 1 : 3)) begin
                  wait_cnt[n] = 0;
                  slot_ready[n] = 1'b1;
                  slot_rdata[n*32 +: 32] = 32'h5A00_0000 | (32'(n) << 16) | 32'(slot_addr);
                  req_cnt[n]++;
                  last_addr[n] = slot_addr;
                  last_we[n]   = slot_write;
                  last_wd[n]   = slot_wdata;
               end
            end
         end
      end
   end

   task automatic xfer(input logic we, input logic [11:0] a, input logic [3:0] be,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = we; bus_addr = a; bus_be = be; bus_wdata = wd;
      @(negedge clk);
      bus_valid = 1'b0;
      #1;
      lat = 1;
      while (!bus_ready && lat < 40) begin
         @(negedge clk); #1;
         lat++;
      end
      rd = bus_ready ? bus_rdata : 32'hDEAD_0000;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      logic [31:0] r; int l;
      xfer(1'b1, a, 4'hF, d, r, l);
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] r; int l;
      xfer(1'b0, a, 4'hF, 32'h0, r, l);
      chk(req, $sformatf("read %h", a), r, exp);
   endtask

   task automatic t_reset();
      rd_chk("R1", 12'h000, 32'h0003_0000);
      rd_chk("R1", 12'h004, 32'h0000_0005);
      rd_chk("R1", 12'h008, 32'h0);
      rd_chk("R1", 12'h0EC, 32'h0);
      rd_chk("R1", 12'h0F0, 32'h0);
      rd_chk("R1", 12'h010, CAP_DEF);
      rd_chk("R1", 12'h020, CAP_DEF);
      rd_chk("R1", 12'h018, 32'h0);
      rd_chk("R1", 12'h028, 32'h0);
      rd_chk("R1", 12'h0FC, 32'h0);
      chk("R1", "slot_cap port", slot_cap[31:0], CAP_DEF);
      chk("R1", "slot_cap port 1", slot_cap[63:32], CAP_DEF);
      chk("R1", "irq", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_timing();
      logic [31:0] r; int l;
      xfer(1'b0, 12'h004, 4'hF, 32'h0, r, l);
      chk("R3", "read latency", 32'(l), 32'd1);
      chk("R3", "read data", r, 32'h5);
      @(negedge clk); #1;
      chk("R3", "ready one cycle", {31'h0, bus_ready}, 32'h0);
      xfer(1'b1, 12'h040, 4'hF, 32'hCAFE_F00D, r, l);
      chk("R3", "write latency", 32'(l), 32'd1);
      chk("R3", "write rdata", r, 32'h0);
   endtask

   task automatic t_storage();
      wr(12'h008, 32'hDEAD_BEEF);
      wr(12'h0EC, 32'h1234_5678);
      wr(12'h0F0, 32'h0000_00A5);
      wr(12'h000, 32'h0);
      wr(12'h004, 32'h8765_4321);
      rd_chk("R2", 12'h008, 32'hDEAD_BEEF);
      rd_chk("R2", 12'h0EC, 32'h1234_5678);
      rd_chk("R2", 12'h0F0, 32'h0000_00A5);
      rd_chk("R2", 12'h040, 32'hCAFE_F00D);
      rd_chk("R2", 12'h000, 32'h0);
      rd_chk("R2", 12'h004, 32'h8765_4321);
      rd_chk("R2", 12'h00C, 32'h0);
   endtask

   task automatic t_alias();
      wr(12'h010, 32'h1111_0000);
      wr(12'h018, 32'h0000_0022);
      wr(12'h020, 32'h3333_0000);
      wr(12'h028, 32'h0000_0044);
      rd_chk("R4", 12'h010, 32'h1111_0000);
      rd_chk("R4", 12'h018, 32'h0000_0022);
      rd_chk("R4", 12'h020, 32'h3333_0000);
      rd_chk("R4", 12'h028, 32'h0000_0044);
      chk("R4", "slot_cap 0", slot_cap[31:0], 32'h1111_0000);
      chk("R4", "slot_cap 1", slot_cap[63:32], 32'h3333_0000);
      chk("R4", "slot_maxcur 0", slot_maxcur[31:0], 32'h22);
      chk("R4", "slot_maxcur 1", slot_maxcur[63:32], 32'h44);
      rd_chk("R4", 12'h014, 32'h0);
      rd_chk("R4", 12'h024, 32'h0);
   endtask

   task automatic t_status();
      @(negedge clk);
      slot_irq = 2'b01;
      @(negedge clk); #1;
      chk("R7", "irq after 1 cycle", {31'h0, irq}, 32'h0);
      @(negedge clk); #1;
      chk("R7", "irq after 2 cycles", {31'h0, irq}, 32'h1);
      rd_chk("R5", 12'h0FC, 32'h1);
      wr(12'h0FC, 32'hFFFF_FFFF);
      rd_chk("R6", 12'h0FC, 32'h1);
      wr(12'h0FC, 32'h0);
      slot_irq = 2'b11;
      rd_chk("R6", 12'h0FC, 32'h3);
      @(negedge clk);
      slot_irq = 2'b10;
      rd_chk("R5", 12'h0FC, 32'h2);
      @(negedge clk);
      slot_irq = 2'b00;
      @(negedge clk); #1;
      chk("R7", "irq held 1 cycle", {31'h0, irq}, 32'h1);
      @(negedge clk); #1;
      chk("R7", "irq low after 2", {31'h0, irq}, 32'h0);
      rd_chk("R5", 12'h0FC, 32'h0);
   endtask

   task automatic t_forward();
      logic [31:0] r; int l;
      int c0, c1;
      c0 = req_cnt[0]; c1 = req_cnt[1];
      xfer(1'b1, 12'h1A4, 4'hF, 32'hABCD_0123, r, l);
      chk("R8", "slot0 count", 32'(req_cnt[0]), 32'(c0 + 1));
      chk("R8", "slot1 untouched", 32'(req_cnt[1]), 32'(c1));
      chk("R8", "slot0 addr", {24'h0, last_addr[0]}, 32'hA4);
      chk("R8", "slot0 we", {31'h0, last_we[0]}, 32'h1);
      chk("R8", "slot0 wdata", last_wd[0], 32'hABCD_0123);
      xfer(1'b0, 12'h23C, 4'hF, 32'h0, r, l);
      chk("R8", "slot1 rdata", r, 32'h5A01_003C);
      chk("R8", "slot1 latency", 32'(l), 32'd3);
      chk("R8", "slot1 we", {31'h0, last_we[1]}, 32'h0);
      chk("R8", "slot0 not hit", 32'(req_cnt[0]), 32'(c0 + 1));
      xfer(1'b0, 12'h110, 4'hF, 32'h0, r, l);
      chk("R8", "slot0 rdata", r, 32'h5A00_0010);
      rd_chk("R8", 12'h010, 32'h1111_0000);
   endtask

   task automatic t_unmapped();
      logic [31:0] r; int l;
      int c0, c1;
      c0 = req_cnt[0]; c1 = req_cnt[1];
      wr(12'h308, 32'hFFFF_FFFF);
      wr(12'hF10, 32'hFFFF_FFFF);
      rd_chk("R9", 12'h008, 32'hDEAD_BEEF);
      rd_chk("R9", 12'h010, 32'h1111_0000);
      xfer(1'b0, 12'h308, 4'hF, 32'h0, r, l);
      chk("R9", "read 0x308", r, 32'h0);
      chk("R9", "latency 0x308", 32'(l), 32'd1);
      xfer(1'b0, 12'hFF0, 4'hF, 32'h0, r, l);
      chk("R9", "read 0xFF0", r, 32'h0);
      chk("R9", "no slot reqs", 32'(req_cnt[0] + req_cnt[1]), 32'(c0 + c1));
   endtask

   task automatic t_partial();
      logic [31:0] r; int l;
      int c0;
      c0 = req_cnt[0];
      xfer(1'b1, 12'h008, 4'h3, 32'h0000_0000, r, l);
      chk("R10", "partial write latency", 32'(l), 32'd1);
      rd_chk("R10", 12'h008, 32'hDEAD_BEEF);
      xfer(1'b1, 12'h00A, 4'hF, 32'h0000_0000, r, l);
      rd_chk("R10", 12'h008, 32'hDEAD_BEEF);
      xfer(1'b0, 12'h004, 4'h1, 32'h0, r, l);
      chk("R10", "partial read zero", r, 32'h0);
      chk("R10", "partial read latency", 32'(l), 32'd1);
      xfer(1'b1, 12'h010, 4'hE, 32'h0, r, l);
      chk("R10", "alias kept", slot_cap[31:0], 32'h1111_0000);
      xfer(1'b0, 12'h104, 4'h7, 32'h0, r, l);
      chk("R10", "partial slot read zero", r, 32'h0);
      chk("R10", "no slot req", 32'(req_cnt[0]), 32'(c0));
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
      slot_irq = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_timing();
      t_storage();
      t_alias();
      t_status();
      t_forward();
      t_unmapped();
      t_partial();
      if (!finished) begin
         finished = 1;
         summary();
         $finish;
      end
   end

endmodule